// File: doc/BRIEF.md
# Pipelined Fixed-Point Multiply-Accumulate

This unit multiplies two 16-bit operands and folds the product into a 40-bit running accumulator. It takes one operand pair per clock and delivers the matching result two clocks later, so a burst of N products completes in N+1 cycles. The accumulator is eight bits wider than a full 32-bit product, which lets long sums grow without losing their top bits.

Each input word carries its own control bits. These choose signed or unsigned operands, plain integer or Q15 fractional format, negation of the product, and whether the product adds to the accumulator or replaces it. A separate bit asks for rounding of the 16-bit result word. The result word is always the high half of the 32-bit product window, and it saturates when the wide accumulator no longer fits that window.

A built-in down-counter tracks the length of an inner loop. It marks the last product of each loop, and that mark arrives at the output together with the result of that product.

Top module: `fxmac`

## Requirements
- R1: An input with `in_valid`=1 sampled at clock edge k gives `out_valid`=1 after edge k+1. Back-to-back inputs give back-to-back results. A cycle with no valid input gives `out_valid`=0 two edges later.
- R2: When `in_signed`=1 the operands are two's complement. When `in_signed`=0 they are unsigned. With `in_q15`=0 the product is the plain integer product.
- R3: With `in_q15`=1 the product is doubled (shifted left by one bit) before it is used, so a Q15 times Q15 product lands in Q1.31 position.
- R4: With `in_neg`=1 the product is replaced by its two's-complement negative before it is accumulated or loaded.
- R5: With `in_accum`=1 the product is added to the 40-bit accumulator, which wraps modulo 2^40. With `in_accum`=0 the accumulator is loaded with the product. `out_acc` shows the accumulator.
- R6: In cycles without a valid input, the operand and control inputs have no effect. `out_acc`, `out_res` and `out_sat` hold their values.
- R7: `out_res` is bits [31:16] of the value V, where V is the updated accumulator. When `in_round`=1, V is the accumulator plus 2^15. Rounding never changes the accumulator itself.
- R8: For signed inputs, `out_res` saturates when V > 2^31-1 (giving 0x7FFF) or V < -2^31 (giving 0x8000). `out_sat`=1 is raised with that result, and `out_sat`=0 otherwise.
- R9: For unsigned inputs, `out_res` saturates to 0x0000 when V is negative and to 0xFFFF when V > 2^32-1, with `out_sat`=1.
- R10: The first valid input after reset, or after a loop ends, samples `loop_len` as the loop length L. The L-th valid input of the loop is the last one, and its result carries `out_last`=1. L=0 means 256 and L=1 marks every input.
- R11: Changing `loop_len` while a loop is in progress does not change the length of that loop.
- R12: After reset `out_valid`, `out_last`, `out_sat`, `out_res` and `out_acc` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| in_signed | input | 1 | 1: two's-complement operands and signed saturation |
| in_q15 | input | 1 | 1: Q15 format, product doubled |
| in_neg | input | 1 | 1: negate the product |
| in_accum | input | 1 | 1: add to accumulator, 0: load accumulator |
| in_round | input | 1 | 1: round the result word |
| loop_len | input | 8 | Inner-loop length, sampled at loop start (0 = 256) |
| out_valid | output | 1 | Result present |
| out_acc | output | 40 | Accumulator |
| out_res | output | 16 | Rounded and saturated result word |
| out_sat | output | 1 | Result word was clipped |
| out_last | output | 1 | Result belongs to the last product of a loop |

## Verification
Rounding and saturation can act on the same result: the rounding carry alone can push a value that just fits over the 32-bit limit. The bench loads an accumulator with exactly 0x7FFF8000 and then adds a zero product, once with rounding and once without. It expects 0x7FFF with `out_sat`=1 in the first case and 0x7FFF with `out_sat`=0 in the second. A loop end can also fall on a cycle that loads, saturates or wraps the accumulator. Random traffic mixes all control bits with idle gaps and loop lengths that change mid-loop, and a behavioural model checks every cycle.

// File: rtl/fxmac_pkg.sv
package fxmac_pkg;

  // Per-sample control bundle carried with the operands into the multiply stage.
  typedef struct packed {
    logic sgn;    // two's-complement operands
    logic q15;    // fractional format: double the product
    logic neg;    // negate the product
    logic accum;  // add to accumulator (0: load)
    logic rnd;    // round the result word
  } mac_ctl_t;

endpackage

// File: rtl/fxmac_loop_cnt.sv
module fxmac_loop_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] len,
  output logic             last,
  output logic [CNT_W-1:0] cnt_q
);

  // Zero in the count register means "no loop in progress": the next step
  // starts a loop of length len (zero wraps to 2^CNT_W naturally).
  logic [CNT_W-1:0] eff;

  always_comb begin
    eff  = (cnt_q == '0) ? len : cnt_q;
    last = step && (eff == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= last ? '0 : eff - CNT_W'(1);
    end
  end

endmodule

// File: rtl/fxmac_mul_stage.sv
module fxmac_mul_stage
  import fxmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  mac_ctl_t         ctl,
  input  logic             last_in,
  output logic             s1_valid,
  output logic [ACC_W-1:0] s1_prod,
  output logic             s1_accum,
  output logic             s1_rnd,
  output logic             s1_sgn,
  output logic             s1_last
);

  localparam int EXT_W = ACC_W - OP_W;

  // Extend both operands to the accumulator width (sign or zero), multiply,
  // keep the low ACC_W bits, then apply format shift and negation.
  function automatic logic [ACC_W-1:0] form_product(
    input logic [OP_W-1:0] x,
    input logic [OP_W-1:0] y,
    input mac_ctl_t        c
  );
    logic [ACC_W-1:0] xe;
    logic [ACC_W-1:0] ye;
    logic [ACC_W-1:0] p;
    xe = {{EXT_W{c.sgn & x[OP_W-1]}}, x};
    ye = {{EXT_W{c.sgn & y[OP_W-1]}}, y};
    p  = xe * ye;
    if (c.q15) p = p << 1;
    if (c.neg) p = '0 - p;
    return p;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_prod  <= '0;
      s1_accum <= 1'b0;
      s1_rnd   <= 1'b0;
      s1_sgn   <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_last  <= in_valid & last_in;
      if (in_valid) begin
        s1_prod  <= form_product(a, b, ctl);
        s1_accum <= ctl.accum;
        s1_rnd   <= ctl.rnd;
        s1_sgn   <= ctl.sgn;
      end
    end
  end

endmodule

// File: rtl/fxmac_acc_stage.sv
module fxmac_acc_stage #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic [ACC_W-1:0] s1_prod,
  input  logic             s1_accum,
  input  logic             s1_rnd,
  input  logic             s1_sgn,
  input  logic             s1_last,
  output logic [ACC_W-1:0] acc_q,
  output logic             out_valid,
  output logic [OP_W-1:0]  out_res,
  output logic             out_sat,
  output logic             out_last,
  output logic             sat_hit
);

  localparam int WIN_W = 2 * OP_W;            // product window width
  localparam int TOP_W = ACC_W - WIN_W + 2;   // guard bits plus window sign

  // Round (add half of a result LSB) in ACC_W+1 bits, then clip to the
  // 2*OP_W window and take its upper OP_W bits. Returns {sat, word}.
  function automatic logic [OP_W:0] round_sat(
    input logic [ACC_W-1:0] v,
    input logic             rnd,
    input logic             sgn
  );
    logic [ACC_W:0]   r;
    logic [ACC_W:0]   half;
    logic [TOP_W-1:0] top;
    half           = '0;
    half[OP_W-1]   = rnd;
    r              = {v[ACC_W-1], v} + half;
    top            = r[ACC_W:WIN_W-1];
    if (sgn) begin
      if ((&top) || !(|top)) return {1'b0, r[WIN_W-1:OP_W]};
      else if (r[ACC_W])     return {1'b1, 1'b1, {(OP_W-1){1'b0}}};
      else                   return {1'b1, 1'b0, {(OP_W-1){1'b1}}};
    end else begin
      if (r[ACC_W])                  return {1'b1, {OP_W{1'b0}}};
      else if (|r[ACC_W-1:WIN_W])    return {1'b1, {OP_W{1'b1}}};
      else                           return {1'b0, r[WIN_W-1:OP_W]};
    end
  endfunction

  logic [ACC_W-1:0] acc_next;
  logic [OP_W:0]    rs;

  always_comb begin
    acc_next = s1_accum ? (acc_q + s1_prod) : s1_prod;
    rs       = round_sat(acc_next, s1_rnd, s1_sgn);
    sat_hit  = s1_valid & rs[OP_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_res   <= '0;
      out_sat   <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_last  <= s1_valid & s1_last;
      if (s1_valid) begin
        acc_q   <= acc_next;
        out_res <= rs[OP_W-1:0];
        out_sat <= rs[OP_W];
      end
    end
  end

endmodule

// File: rtl/fxmac.sv
module fxmac
  import fxmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_a,
  input  logic [OP_W-1:0]  in_b,
  input  logic             in_signed,
  input  logic             in_q15,
  input  logic             in_neg,
  input  logic             in_accum,
  input  logic             in_round,
  input  logic [CNT_W-1:0] loop_len,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_acc,
  output logic [OP_W-1:0]  out_res,
  output logic             out_sat,
  output logic             out_last
);

  mac_ctl_t         in_ctl;
  logic             loop_last;
  logic [CNT_W-1:0] loop_cnt;
  logic             s1_valid;
  logic [ACC_W-1:0] s1_prod;
  logic             s1_accum;
  logic             s1_rnd;
  logic             s1_sgn;
  logic             s1_last;
  logic             sat_hit;

  always_comb begin
    in_ctl.sgn   = in_signed;
    in_ctl.q15   = in_q15;
    in_ctl.neg   = in_neg;
    in_ctl.accum = in_accum;
    in_ctl.rnd   = in_round;
  end

  fxmac_loop_cnt #(.CNT_W(CNT_W)) u_loop (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (in_valid),
    .len   (loop_len),
    .last  (loop_last),
    .cnt_q (loop_cnt)
  );

  fxmac_mul_stage #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .a        (in_a),
    .b        (in_b),
    .ctl      (in_ctl),
    .last_in  (loop_last),
    .s1_valid (s1_valid),
    .s1_prod  (s1_prod),
    .s1_accum (s1_accum),
    .s1_rnd   (s1_rnd),
    .s1_sgn   (s1_sgn),
    .s1_last  (s1_last)
  );

  fxmac_acc_stage #(.OP_W(OP_W), .ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_prod   (s1_prod),
    .s1_accum  (s1_accum),
    .s1_rnd    (s1_rnd),
    .s1_sgn    (s1_sgn),
    .s1_last   (s1_last),
    .acc_q     (out_acc),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_sat   (out_sat),
    .out_last  (out_last),
    .sat_hit   (sat_hit)
  );

endmodule

// File: rtl/fxmac_chk.sv
module fxmac_chk #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             loop_last,
  input logic [CNT_W-1:0] loop_cnt,
  input logic             s1_valid,
  input logic [ACC_W-1:0] s1_prod,
  input logic             s1_accum,
  input logic             sat_hit,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_acc,
  input logic [OP_W-1:0]  out_res,
  input logic             out_sat,
  input logic             out_last
);

  localparam logic [OP_W-1:0] POS_MAX = {1'b0, {(OP_W-1){1'b1}}};
  localparam logic [OP_W-1:0] NEG_MIN = {1'b1, {(OP_W-1){1'b0}}};

  assert_stage_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);

  assert_out_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> ($stable(out_acc) && $stable(out_res) && $stable(out_sat)));

  assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_accum) |=> (out_acc == $past(s1_prod)));

  assert_sat_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_sat |-> (out_res == POS_MAX || out_res == NEG_MIN ||
                 out_res == '0 || out_res == '1));

  assert_sat_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |=> (out_sat && out_valid));

  assert_last_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_loop_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    loop_last |=> (loop_cnt == '0));

  assert_loop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(loop_cnt));

endmodule

bind fxmac fxmac_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .loop_last (loop_last),
  .loop_cnt  (loop_cnt),
  .s1_valid  (s1_valid),
  .s1_prod   (s1_prod),
  .s1_accum  (s1_accum),
  .sat_hit   (sat_hit),
  .out_valid (out_valid),
  .out_acc   (out_acc),
  .out_res   (out_res),
  .out_sat   (out_sat),
  .out_last  (out_last)
);

// File: tb/fxmac_test.sv
module fxmac_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_a, in_b;
  logic        in_signed, in_q15, in_neg, in_accum, in_round;
  logic [7:0]  loop_len;
  logic        out_valid, out_sat, out_last;
  logic [39:0] out_acc;
  logic [15:0] out_res;

  always #10 clk = ~clk;

  fxmac uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_signed(in_signed), .in_q15(in_q15), .in_neg(in_neg),
    .in_accum(in_accum), .in_round(in_round), .loop_len(loop_len),
    .out_valid(out_valid), .out_acc(out_acc), .out_res(out_res),
    .out_sat(out_sat), .out_last(out_last)
  );

  typedef struct {
    bit v; int a; int b; bit sgn; bit q15; bit neg; bit accf; bit rnd; bit last;
  } smp_t;

  smp_t   pend[$];
  int     checks = 0, failures = 0;
  string  cur_req = "R12";
  int     cur_len = 4;
  longint m_acc = 0;
  bit     m_valid = 0, m_sat = 0, m_last = 0;
  longint m_res = 0;
  int     m_rem = 0;
  localparam longint MASK40 = 64'h0000_00FF_FFFF_FFFF;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid == m_valid, "R1", "out_valid", longint'(out_valid), longint'(m_valid));
    chk(out_last == m_last, "R10", "out_last", longint'(out_last), longint'(m_last));
    chk(longint'(out_acc) == (m_acc & MASK40), cur_req, "out_acc",
        longint'(out_acc), m_acc & MASK40);
    chk(longint'(out_res) == m_res, cur_req, "out_res", longint'(out_res), m_res);
    chk(out_sat == m_sat, cur_req, "out_sat", longint'(out_sat), longint'(m_sat));
  endtask

  // Behavioural model of one result: integers, no bit slicing of the design.
  task automatic apply(smp_t s);
    longint x, y, p, r;
    m_valid = s.v;
    m_last  = s.v && s.last;
    if (s.v) begin
      x = (s.sgn && s.a >= 32768) ? longint'(s.a) - 65536 : longint'(s.a);
      y = (s.sgn && s.b >= 32768) ? longint'(s.b) - 65536 : longint'(s.b);
      p = x * y;
      if (s.q15) p = p * 2;
      if (s.neg) p = -p;
      m_acc = s.accf ? m_acc + p : p;
      m_acc = (m_acc <<< 24) >>> 24;       // 40-bit two's-complement wrap
      r = m_acc + (s.rnd ? 32768 : 0);
      m_sat = 1'b0;
      if (s.sgn) begin
        if (r > 64'sd2147483647)       begin m_res = 'h7FFF; m_sat = 1'b1; end
        else if (r < -64'sd2147483648) begin m_res = 'h8000; m_sat = 1'b1; end
        else m_res = (r >>> 16) & 'hFFFF;
      end else begin
        if (r < 0)                     begin m_res = 0;      m_sat = 1'b1; end
        else if (r > 64'sd4294967295)  begin m_res = 'hFFFF; m_sat = 1'b1; end
        else m_res = (r >>> 16) & 'hFFFF;
      end
    end
  endtask

  task automatic step(bit v, int a, int b, bit sgn, bit q15, bit neg, bit accf, bit rnd);
    smp_t s;
    @(negedge clk);
    compare();
    in_valid = v; in_a = 16'(a); in_b = 16'(b);
    in_signed = sgn; in_q15 = q15; in_neg = neg; in_accum = accf; in_round = rnd;
    loop_len = 8'(cur_len);
    s.v = v; s.a = a & 'hFFFF; s.b = b & 'hFFFF; s.sgn = sgn; s.q15 = q15;
    s.neg = neg; s.accf = accf; s.rnd = rnd; s.last = 1'b0;
    if (v) begin
      if (m_rem == 0) m_rem = (cur_len == 0) ? 256 : cur_len;
      s.last = (m_rem == 1);
      m_rem--;
    end
    pend.push_back(s);
    apply(pend.pop_front());
  endtask

  task automatic mac(int a, int b, bit sgn, bit q15, bit neg, bit accf, bit rnd);
    step(1'b1, a, b, sgn, q15, neg, accf, rnd);
  endtask

  task automatic idle();
    step(1'b0, int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
         1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    smp_t z;
    z = '{default: 0};
    pend.push_back(z);
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    in_signed = 1'b0; in_q15 = 1'b0; in_neg = 1'b0; in_accum = 1'b0;
    in_round = 1'b0; loop_len = 8'd4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state
    chk(out_valid == 0 && out_last == 0 && out_sat == 0 && out_res == 0 && out_acc == 0,
        "R12", "reset outputs", longint'(out_acc), 0);

    // R2: signed and unsigned integer products
    cur_req = "R2";
    mac('h4000, 'h0100, 1, 0, 0, 0, 0);
    mac('hFFFF, 'hFFFF, 0, 0, 0, 0, 0);
    mac('hFFFF, 'hFFFF, 1, 0, 0, 0, 0);
    mac('h8000, 'h7FFF, 1, 0, 0, 0, 0);
    // R3: Q15 products
    cur_req = "R3";
    mac('h4000, 'h4000, 1, 1, 0, 0, 0);
    mac('hC000, 'h4000, 1, 1, 0, 0, 0);
    mac('h8000, 'h8000, 1, 1, 0, 0, 0);
    // R4: negation
    cur_req = "R4";
    mac('h1234, 'h0567, 1, 0, 1, 0, 0);
    mac('h4000, 'h2000, 1, 1, 1, 1, 0);
    // R5: 100 back-to-back accumulations, then a load
    cur_req = "R5";
    for (int i = 0; i < 100; i++) mac(i * 301, 'h7123 - i * 17, 1, 1, i[0], i != 0, 0);
    mac('h0003, 'h0005, 1, 0, 0, 0, 0);
    // R5: 40-bit wrap via repeated +2^31
    for (int i = 0; i < 300; i++) mac('h8000, 'h8000, 1, 1, 0, 1, 0);
    // R6: idle gaps with noise on the inputs
    cur_req = "R6";
    mac('h0100, 'h0200, 1, 0, 0, 0, 0);
    repeat (4) idle();
    mac('h0100, 'h0200, 1, 0, 0, 1, 0);
    repeat (3) idle();
    // R7: rounding adds half an LSB, leaves the accumulator alone
    cur_req = "R7";
    mac('h0080, 'h0100, 1, 0, 0, 0, 1);
    mac('h0000, 'h0000, 1, 0, 0, 1, 0);
    mac('h007F, 'h0100, 1, 0, 0, 0, 1);
    mac('hFF80, 'h0100, 1, 0, 0, 0, 1);
    // R8: rounding carry and saturation in the same result
    cur_req = "R8";
    mac('hFFFF, 'h8000, 0, 0, 0, 0, 0);
    mac('h0000, 'h0000, 1, 0, 0, 1, 1);
    mac('h0000, 'h0000, 1, 0, 0, 1, 0);
    mac('h8000, 'h7FFF, 1, 1, 0, 0, 0);
    mac('h7FFF, 'h0002, 1, 0, 1, 1, 0);
    mac('h7FFF, 'h0002, 1, 0, 1, 1, 0);
    mac('h0000, 'h0000, 1, 0, 0, 1, 1);
    // R9: unsigned saturation
    cur_req = "R9";
    mac('h0005, 'h0007, 0, 0, 1, 0, 0);
    mac('hFFFF, 'hFFFF, 0, 0, 0, 0, 0);
    mac('hFFFF, 'hFFFF, 0, 0, 0, 1, 0);
    mac('hFFFF, 'h0001, 0, 0, 1, 0, 1);
    // R10: loop lengths 3, 1 and 256 (encoded 0) with gaps
    cur_req = "R10";
    repeat (3) idle();
    while (m_rem != 0) mac(1, 1, 1, 0, 0, 1, 0);
    cur_len = 3;
    for (int i = 0; i < 7; i++) begin mac(i, 3, 1, 0, 0, 1, 0); if (i == 2) idle(); end
    while (m_rem != 0) mac(1, 1, 1, 0, 0, 1, 0);
    cur_len = 1;
    repeat (3) mac(2, 2, 1, 0, 0, 1, 0);
    cur_len = 0;
    for (int i = 0; i < 258; i++) mac(i, 5, 0, 0, 0, 1, 0);
    while (m_rem != 0) mac(1, 1, 1, 0, 0, 1, 0);
    // R11: length changes in mid-loop
    cur_req = "R11";
    cur_len = 3;
    mac(1, 1, 1, 0, 0, 0, 0);
    cur_len = 7;
    repeat (2) mac(1, 1, 1, 0, 0, 1, 0);
    repeat (8) mac(1, 1, 1, 0, 0, 1, 0);
    // Mixed random traffic
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      if (i % 37 == 0) cur_len = int'($urandom_range(0, 9));
      step($urandom_range(0, 9) < 8, int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 65535)), 1'($urandom), 1'($urandom), 1'($urandom),
           $urandom_range(0, 9) < 8, 1'($urandom));
    end
    repeat (4) idle();
    finish_run();
  end

endmodule